// File: doc/BRIEF.md
# Token-Ring Controller Command Decoder

This block sits behind the host write port of a token-passing network controller. The host writes one byte at a time into a command register. The block matches each byte against a small set of fixed opcode patterns. Some of these patterns carry operand bits, so one byte can act on more than one thing at once.

One command loads a packet-length mode bit. Another clears any chosen mix of sticky status flags. A third raises a one-cycle pulse that clears the receive interrupt elsewhere in the controller. The sticky flags live inside this block:
- The power-on flag is set by reset.
- The excessive-NAK flag is set by its own event input.
- The reconfiguration flag is set by its own event input.

The host port is a plain write strobe with a data byte. It takes a byte on every cycle the strobe is high and never pushes back, so the host may write back to back without waiting. Every action becomes visible in the cycle after the edge that sampled the write.

Top module: `tpn_cmd_decoder`

## Requirements
- R1: A write of the pattern 0000_c101 (0x05 or 0x0D) loads bit 3 (c) into `long_pkt_en`, visible in the cycle after the write.
- R2: `long_pkt_en` = 1 allows long and short packets, and 0 allows short packets only. Reset forces it to 0.
- R3: A write of the pattern 000r_p110 with p (bit 3) = 1 clears both `stat_por` and `stat_excnak`.
- R4: In the same pattern, r (bit 4) = 1 clears `stat_recon`. The p and r operands act independently of each other.
- R5: A write of exactly 0x08 makes `clr_rx_irq` high for exactly the one cycle after the write.
- R6: Reset sets `stat_por` to 1. After reset, nothing but the clear command changes it.
- R7: A high `evt_excnak` sets `stat_excnak`, and a high `evt_recon` sets `stat_recon`. Each flag stays set until it is cleared.
- R8: When a set event and a clear command hit the same flag in the same cycle, the flag ends up set.
- R9: A byte that matches no pattern, and any byte presented while `wr_en` is low, changes no output.
- R10: The block accepts a byte on every cycle and has no back-pressure. Back-to-back writes each take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe; the byte is taken when high |
| wr_data | input | 8 | Command byte |
| evt_excnak | input | 1 | Event pulse that sets the excessive-NAK flag |
| evt_recon | input | 1 | Event pulse that sets the reconfiguration flag |
| long_pkt_en | output | 1 | Packet-length mode: 1 = long and short, 0 = short only |
| stat_por | output | 1 | Sticky power-on flag |
| stat_excnak | output | 1 | Sticky excessive-NAK flag |
| stat_recon | output | 1 | Sticky reconfiguration flag |
| clr_rx_irq | output | 1 | One-cycle clear-receive-interrupt pulse |

## Verification
The hardest case to reach from the ports is a set event and a clear command striking the same flag in the same cycle. To get there, the stimulus table first drives the event inputs so the flags are set. It then pairs a clear-flags byte with a simultaneous event pulse, both for the reconfiguration flag and for the excessive-NAK flag. The table also checks that the other operand of the same byte still clears its own flag. Near-miss bytes, such as 0x0C, 0xFF and 0x0D presented with the strobe low, are placed where flags are set, so that any wrongly taken action would show at the outputs.

// File: rtl/tpn_cmd_pkg.sv
package tpn_cmd_pkg;
  localparam int CMD_W  = 8;
  localparam int FLAG_N = 3;

  // flag slots
  localparam int IDX_POR    = 0;
  localparam int IDX_EXCNAK = 1;
  localparam int IDX_RECON  = 2;

  // opcode patterns: (byte & MASK) == CODE
  localparam logic [CMD_W-1:0] CFG_MASK = 8'hF7;
  localparam logic [CMD_W-1:0] CFG_CODE = 8'h05;
  localparam int               CFG_BIT  = 3;

  localparam logic [CMD_W-1:0] CLR_MASK  = 8'hE7;
  localparam logic [CMD_W-1:0] CLR_CODE  = 8'h06;
  localparam int               CLR_P_BIT = 3;
  localparam int               CLR_R_BIT = 4;

  localparam logic [CMD_W-1:0] RXI_CODE = 8'h08;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_CFG  = 2'd1,
    CMD_CLR  = 2'd2,
    CMD_RXI  = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e kind;
    logic      cfg_val;
    logic      clr_p;
    logic      clr_r;
  } cmd_dec_t;
endpackage

// File: rtl/tpn_cmd_match.sv
module tpn_cmd_match
  import tpn_cmd_pkg::*;
(
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  output cmd_dec_t         dec
);
  logic hit_cfg, hit_clr, hit_rxi;

  always_comb begin
    hit_cfg = ((wr_data & CFG_MASK) == CFG_CODE);
    hit_clr = ((wr_data & CLR_MASK) == CLR_CODE);
    hit_rxi = (wr_data == RXI_CODE);

    dec = '{kind: CMD_NONE, cfg_val: 1'b0, clr_p: 1'b0, clr_r: 1'b0};
    if (wr_en) begin
      if (hit_cfg) begin
        dec.kind    = CMD_CFG;
        dec.cfg_val = wr_data[CFG_BIT];
      end else if (hit_clr) begin
        dec.kind  = CMD_CLR;
        dec.clr_p = wr_data[CLR_P_BIT];
        dec.clr_r = wr_data[CLR_R_BIT];
      end else if (hit_rxi) begin
        dec.kind = CMD_RXI;
      end
    end
  end
endmodule

// File: rtl/tpn_sticky_bit.sv
module tpn_sticky_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;   // set has priority over clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/tpn_cfg_reg.sv
module tpn_cfg_reg #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= {W{RST_VAL}};
    else if (load_i) q_o <= val_i;
  end
endmodule

// File: rtl/tpn_cmd_decoder.sv
module tpn_cmd_decoder
  import tpn_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             evt_excnak,
  input  logic             evt_recon,
  output logic             long_pkt_en,
  output logic             stat_por,
  output logic             stat_excnak,
  output logic             stat_recon,
  output logic             clr_rx_irq
);
  cmd_dec_t           dec;
  logic [FLAG_N-1:0]  flag_set, flag_clr, flag_q;
  logic [FLAG_N-1:0]  flag_rst;
  logic               rxi_q;

  tpn_cmd_match u_match (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .dec     (dec)
  );

  tpn_cfg_reg #(.W(1), .RST_VAL(1'b0)) u_len_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (dec.kind == CMD_CFG),
    .val_i  (dec.cfg_val),
    .q_o    (long_pkt_en)
  );

  always_comb begin
    flag_set             = '0;
    flag_set[IDX_EXCNAK] = evt_excnak;
    flag_set[IDX_RECON]  = evt_recon;

    flag_clr             = '0;
    flag_clr[IDX_POR]    = (dec.kind == CMD_CLR) && dec.clr_p;
    flag_clr[IDX_EXCNAK] = (dec.kind == CMD_CLR) && dec.clr_p;
    flag_clr[IDX_RECON]  = (dec.kind == CMD_CLR) && dec.clr_r;

    flag_rst          = '0;
    flag_rst[IDX_POR] = 1'b1;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    tpn_sticky_bit #(.RST_VAL(i == IDX_POR)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set[i]),
      .clr_i (flag_clr[i]),
      .q_o   (flag_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rxi_q <= 1'b0;
    else        rxi_q <= (dec.kind == CMD_RXI);
  end

  assign stat_por    = flag_q[IDX_POR];
  assign stat_excnak = flag_q[IDX_EXCNAK];
  assign stat_recon  = flag_q[IDX_RECON];
  assign clr_rx_irq  = rxi_q;

  logic unused_rst;
  assign unused_rst = ^flag_rst;
endmodule

// File: rtl/tpn_cmd_decoder_chk.sv
module tpn_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       evt_excnak,
  input logic       evt_recon,
  input logic       long_pkt_en,
  input logic       stat_por,
  input logic       stat_excnak,
  input logic       stat_recon,
  input logic       clr_rx_irq
);
  logic is_cfg, is_clr, is_rxi;
  assign is_cfg = wr_en && ((wr_data & 8'hF7) == 8'h05);
  assign is_clr = wr_en && ((wr_data & 8'hE7) == 8'h06);
  assign is_rxi = wr_en && (wr_data == 8'h08);

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    is_cfg |=> (long_pkt_en == $past(wr_data[3]))); // R1
  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cfg |=> $stable(long_pkt_en)); // R9
  AST_P_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_clr && wr_data[3] && !evt_excnak) |=> (!stat_por && !stat_excnak)); // R3
  AST_R_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_clr && wr_data[4] && !evt_recon) |=> !stat_recon); // R4
  AST_RXI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    is_rxi |=> clr_rx_irq); // R5
  AST_RXI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_rxi) |=> !clr_rx_irq); // R5
  AST_POR_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_por |=> !stat_por); // R6
  AST_RECON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_recon && !(is_clr && wr_data[4])) |=> stat_recon); // R7
  AST_EXCNAK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_excnak |=> stat_excnak); // R8
  AST_RECON_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_recon |=> stat_recon); // R8
endmodule

bind tpn_cmd_decoder tpn_cmd_decoder_chk u_chk (.*);

// File: tb/tb_tpn_cmd_decoder.sv
`timescale 1ns/1ps
module tb_tpn_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       evt_excnak, evt_recon;
  logic       long_pkt_en, stat_por, stat_excnak, stat_recon, clr_rx_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tpn_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .evt_excnak(evt_excnak), .evt_recon(evt_recon),
    .long_pkt_en(long_pkt_en), .stat_por(stat_por), .stat_excnak(stat_excnak),
    .stat_recon(stat_recon), .clr_rx_irq(clr_rx_irq)
  );

  // vector: [15] wr_en, [14:7] data, [6] evt_recon, [5] evt_excnak,
  //         [4:0] expected {long, por, excnak, recon, irq}
  localparam int NV = 18;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 8'h0D, 1'b0, 1'b0, 5'b11000},  // R1 c=1 -> long mode
    {1'b0, 8'h00, 1'b1, 1'b1, 5'b11110},  // R7 events set flags
    {1'b0, 8'h00, 1'b0, 1'b0, 5'b11110},  // R7 flags hold
    {1'b1, 8'h0E, 1'b0, 1'b0, 5'b10010},  // R3 p clears por+excnak only
    {1'b1, 8'h08, 1'b0, 1'b0, 5'b10011},  // R5 pulse
    {1'b1, 8'h16, 1'b0, 1'b0, 5'b10000},  // R4 r clears recon, pulse gone
    {1'b1, 8'h05, 1'b0, 1'b0, 5'b00000},  // R1 R2 c=0 -> short only
    {1'b0, 8'h00, 1'b1, 1'b1, 5'b00110},  // R7
    {1'b1, 8'hFF, 1'b0, 1'b0, 5'b00110},  // R9 unmatched
    {1'b1, 8'h0C, 1'b0, 1'b0, 5'b00110},  // R9 near-miss of cfg
    {1'b0, 8'h0D, 1'b0, 1'b0, 5'b00110},  // R9 strobe low
    {1'b0, 8'h1E, 1'b0, 1'b0, 5'b00110},  // R9 strobe low
    {1'b1, 8'h1E, 1'b1, 1'b0, 5'b00010},  // R8 recon set wins, excnak cleared
    {1'b1, 8'h1E, 1'b0, 1'b0, 5'b00000},  // R3 R4 both clear
    {1'b1, 8'h0E, 1'b0, 1'b1, 5'b00100},  // R8 excnak set wins
    {1'b1, 8'h08, 1'b0, 1'b0, 5'b00101},  // R10 back-to-back pulse 1
    {1'b1, 8'h08, 1'b0, 1'b0, 5'b00101},  // R10 back-to-back pulse 2
    {1'b1, 8'h0D, 1'b0, 1'b0, 5'b10100}   // R10 next byte taken at once
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_all(input logic [4:0] e, input string tag);
    chk({tag, " R1/R2"}, "long_pkt_en", long_pkt_en, e[4]);
    chk({tag, " R3/R6"}, "stat_por",    stat_por,    e[3]);
    chk({tag, " R3/R7"}, "stat_excnak", stat_excnak, e[2]);
    chk({tag, " R4/R7"}, "stat_recon",  stat_recon,  e[1]);
    chk({tag, " R5"},    "clr_rx_irq",  clr_rx_irq,  e[0]);
  endtask

  task automatic drive(input logic we, input logic [7:0] d, input logic er, input logic ex);
    wr_en = we; wr_data = d; evt_recon = er; evt_excnak = ex;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00; evt_recon = 1'b0; evt_excnak = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; evt_recon = 1'b0; evt_excnak = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all(5'b01000, "reset R2 R6");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][15], VEC[i][14:7], VEC[i][6], VEC[i][5]);
      check_all(VEC[i][4:0], $sformatf("vec%0d", i));
    end

    // R5: pulse lasts one cycle only
    drive(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R5", "clr_rx_irq after idle", clr_rx_irq, 1'b0);

    // R6: reset mid-run restores power-on flag and short mode
    drive(1'b1, 8'h0E, 1'b0, 1'b0);
    chk("R6", "stat_por cleared", stat_por, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_all(5'b01000, "rerun R2 R6");

    // R6: events never set the power-on flag
    drive(1'b1, 8'h0E, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 1'b1, 1'b1);
    chk("R6", "stat_por after events", stat_por, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (10000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule